// File: doc/BRIEF.md
# Branch Target Trace Encoder

This block sits between a processor core's change-of-flow reporting and a trace buffer. For each accepted taken-branch event it sends a short series of 6-bit trace entries over a valid/ready output. The first entry is always the taken-branch status code. If the branch used a computed destination and target capture is enabled, a size marker follows. After the marker come the target address bits, shifted right by one and sent one tagged nibble per entry, least significant nibble first.

Each entry is framed as a 2-bit tag above a 4-bit payload. Tag `00` carries a code: status `0x5` gives entry `6'h05`, the two-byte marker `0xD` gives `6'h0D`, and the three-byte marker `0xE` gives `6'h0E`. Tag `10` carries one address nibble. While a series is in progress the encoder holds its input-ready low. The target, the variant flag and both configuration bits are captured at acceptance, so changes on those inputs during a series have no effect.

The controller has four states. In IDLE it waits for an event, and accepting one moves it to STATUS. From STATUS it moves to MARKER when capture applies and back to IDLE otherwise. MARKER moves to ADDR. ADDR stays in ADDR until the last nibble is taken, then returns to IDLE. Each move out of STATUS, MARKER or ADDR happens on an output handshake. Reset from any state goes to IDLE.

Top module: `brtgt_trace_enc`

## Requirements
- R1: After synchronous active-high reset, `ent_valid` is 0 and `br_ready` is 1.
- R2: The first entry of every accepted event is `6'h05` (tag `00`, code `0x5`), and it is presented in the cycle after acceptance.
- R3: Marker and address entries follow only when `br_variant` and `cfg_capture_en` were both 1 at acceptance. Otherwise the series is the single `6'h05` entry.
- R4: The marker entry is `6'h0D` when `cfg_long_addr` was 0 at acceptance and `6'h0E` when it was 1.
- R5: After the marker come 4 address entries (short mode) or 6 (long mode). Entry k is `{2'b10, target[4k+4:4k+1]}`, with k starting at 0.
- R6: `br_ready` is 0 while any entry of a series is pending. It returns to 1 in the cycle after the last entry is taken.
- R7: While `ent_valid` is 1 and `ent_ready` is 0, `ent_valid` and `ent_data` hold their values into the next cycle.
- R8: Changes to `br_target`, `br_variant`, `cfg_capture_en` or `cfg_long_addr` after acceptance do not change the series in progress.
- R9: Reset during a series drops all pending entries. The encoder is idle and emits nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Taken-branch event strobe |
| br_ready | output | 1 | Encoder can accept an event |
| br_variant | input | 1 | Branch destination was computed |
| br_target | input | 32 | Branch target address |
| cfg_capture_en | input | 1 | Enable target capture |
| cfg_long_addr | input | 1 | 1: three address bytes, 0: two |
| ent_valid | output | 1 | Trace entry valid |
| ent_ready | input | 1 | Trace buffer accepts entry |
| ent_data | output | 6 | Trace entry {tag, payload} |

## Verification
The assertions assume that `rst` is a clean synchronous level and that an event is taken only when `br_valid` and `br_ready` are high in the same cycle. They also assume the buffer side may drop `ent_ready` at any time. The bench drives event inputs only at falling edges and raises `br_valid` only while the encoder is idle. It gates `ent_ready` with repeating stall patterns to exercise the hold checks. In some runs it deliberately changes the target and configuration inputs mid-series, which the design must ignore.

// File: rtl/btte_pkg.sv
package btte_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STATUS,
        ST_MARKER,
        ST_ADDR
    } btte_state_e;

    localparam int TAG_W   = 2;
    localparam int NIB_W   = 4;
    localparam int ENTRY_W = TAG_W + NIB_W;

    localparam logic [TAG_W-1:0] TAG_CODE = 2'b00;
    localparam logic [TAG_W-1:0] TAG_ADDR = 2'b10;

    localparam logic [NIB_W-1:0] CODE_TAKEN = 4'h5;
    localparam logic [NIB_W-1:0] CODE_SZ2   = 4'hD;
    localparam logic [NIB_W-1:0] CODE_SZ3   = 4'hE;
endpackage

// File: rtl/btte_nib_sel.sv
module btte_nib_sel #(
    parameter int ADDR_W  = 32,
    parameter int NIB_CNT = 6,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [IDX_W-1:0]          idx,
    output logic [btte_pkg::NIB_W-1:0] nib
);
    localparam int NW = btte_pkg::NIB_W;

    logic [ADDR_W-2:0] shifted;
    logic [NW-1:0]     nibs [NIB_CNT];

    assign shifted = addr[ADDR_W-1:1];

    genvar g;
    generate
        for (g = 0; g < NIB_CNT; g++) begin : g_nib
            assign nibs[g] = shifted[g*NW +: NW];
        end
    endgenerate

    always_comb begin
        nib = '0;
        for (int i = 0; i < NIB_CNT; i++) begin
            if (idx == IDX_W'(i)) nib = nibs[i];
        end
    end
endmodule

// File: rtl/btte_ctrl.sv
module btte_ctrl
    import btte_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SHORT_BYTES = 2,
    parameter int LONG_BYTES  = 3,
    parameter int IDX_W       = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               br_valid,
    output logic               br_ready,
    input  logic               br_variant,
    input  logic [ADDR_W-1:0]  br_target,
    input  logic               cfg_capture_en,
    input  logic               cfg_long_addr,
    output logic               ent_valid,
    input  logic               ent_ready,
    output logic [ENTRY_W-1:0] ent_data,
    output logic [ADDR_W-1:0]  held_addr,
    output logic [IDX_W-1:0]   nib_idx,
    input  logic [NIB_W-1:0]   nib_val
);
    localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_BYTES * 2 - 1);
    localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_BYTES * 2 - 1);

    btte_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              long_q, cap_q;
    logic              accept;
    logic [IDX_W-1:0]  last_idx;

    assign accept   = br_valid && (state_q == ST_IDLE);
    assign last_idx = long_q ? LONG_LAST : SHORT_LAST;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_STATUS;
            ST_STATUS: if (ent_ready) state_d = cap_q ? ST_MARKER : ST_IDLE;
            ST_MARKER: if (ent_ready) state_d = ST_ADDR;
            ST_ADDR:   if (ent_ready && idx_q == last_idx) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            addr_q  <= '0;
            long_q  <= 1'b0;
            cap_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= br_target;
                long_q <= cfg_long_addr;
                cap_q  <= cfg_capture_en && br_variant;
            end
            if (state_q == ST_MARKER)
                idx_q <= '0;
            else if (state_q == ST_ADDR && ent_ready)
                idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        br_ready  = (state_q == ST_IDLE);
        ent_valid = (state_q != ST_IDLE);
        held_addr = addr_q;
        nib_idx   = idx_q;
        unique case (state_q)
            ST_STATUS: ent_data = {TAG_CODE, CODE_TAKEN};
            ST_MARKER: ent_data = {TAG_CODE, long_q ? CODE_SZ3 : CODE_SZ2};
            ST_ADDR:   ent_data = {TAG_ADDR, nib_val};
            default:   ent_data = '0;
        endcase
    end

    // R1: reset state
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!ent_valid && br_ready));

    // R2: acceptance presents the status entry next cycle
    p_accept_status_r2: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_ready) |=> (ent_valid && ent_data == {TAG_CODE, CODE_TAKEN}));

    // R6: no new event while a series is pending
    p_busy_block_r6: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> !br_ready);

    // R7: stalled entry is held
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_data)));
endmodule

// File: rtl/brtgt_trace_enc.sv
module brtgt_trace_enc #(
    parameter int ADDR_W      = 32,
    parameter int SHORT_BYTES = 2,
    parameter int LONG_BYTES  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_valid,
    output logic              br_ready,
    input  logic              br_variant,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              cfg_capture_en,
    input  logic              cfg_long_addr,
    output logic              ent_valid,
    input  logic              ent_ready,
    output logic [5:0]        ent_data
);
    localparam int NIB_CNT = LONG_BYTES * 2;
    localparam int IDX_W   = $clog2(NIB_CNT);

    logic [ADDR_W-1:0]          held_addr;
    logic [IDX_W-1:0]           nib_idx;
    logic [btte_pkg::NIB_W-1:0] nib_val;

    btte_ctrl #(
        .ADDR_W(ADDR_W), .SHORT_BYTES(SHORT_BYTES),
        .LONG_BYTES(LONG_BYTES), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .br_valid(br_valid), .br_ready(br_ready),
        .br_variant(br_variant), .br_target(br_target),
        .cfg_capture_en(cfg_capture_en), .cfg_long_addr(cfg_long_addr),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_data(ent_data),
        .held_addr(held_addr), .nib_idx(nib_idx), .nib_val(nib_val)
    );

    btte_nib_sel #(
        .ADDR_W(ADDR_W), .NIB_CNT(NIB_CNT), .IDX_W(IDX_W)
    ) u_sel (
        .addr(held_addr), .idx(nib_idx), .nib(nib_val)
    );
endmodule

// File: tb/test_brtgt_trace_enc.sv
`timescale 1ns/1ps
module test_brtgt_trace_enc;
    logic        clk = 0;
    logic        rst = 1;
    logic        br_valid = 0;
    logic        br_ready;
    logic        br_variant = 0;
    logic [31:0] br_target = '0;
    logic        cfg_capture_en = 0;
    logic        cfg_long_addr = 0;
    logic        ent_valid;
    logic        ent_ready = 1;
    logic [5:0]  ent_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [5:0] got [16];
    int         got_n;
    logic [5:0] expv [16];
    int         exp_n;

    always #2.5 clk = ~clk;

    brtgt_trace_enc i_brtgt_trace_enc (
        .clk(clk), .rst(rst),
        .br_valid(br_valid), .br_ready(br_ready),
        .br_variant(br_variant), .br_target(br_target),
        .cfg_capture_en(cfg_capture_en), .cfg_long_addr(cfg_long_addr),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_data(ent_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d cycles exp<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic build_exp(input logic [31:0] t, input bit var_b, input bit cap, input bit lng);
        exp_n = 0;
        expv[exp_n++] = 6'h05;
        if (var_b && cap) begin
            expv[exp_n++] = lng ? 6'h0E : 6'h0D;
            for (int k = 0; k < (lng ? 6 : 4); k++)
                expv[exp_n++] = {2'b10, 4'((t >> (4 * k + 1)) & 32'hF)};
        end
    endtask

    // Issue one event, collect its series with an optional stall pattern
    task automatic run_branch(input logic [31:0] t, input bit var_b, input bit cap,
                              input bit lng, input int stall, input bit disturb);
        logic [5:0] prev_d;
        bit         prev_stall;
        @(negedge clk);
        br_valid = 1; br_target = t; br_variant = var_b;
        cfg_capture_en = cap; cfg_long_addr = lng;
        @(negedge clk);
        br_valid = 0;
        if (disturb) begin
            br_target = ~t; br_variant = ~var_b;
            cfg_capture_en = ~cap; cfg_long_addr = ~lng;
        end
        check(ent_valid && ent_data == 6'h05, "R2 first", ent_data, 6'h05);
        got_n = 0;
        prev_stall = 0;
        prev_d = '0;
        for (int c = 0; c < 60; c++) begin
            if (!ent_valid) break;
            if (prev_stall)
                check(ent_data == prev_d, "R7 hold", ent_data, prev_d);
            ent_ready = (stall == 0) ? 1'b1 : ((c % stall) != 0);
            check(!br_ready, "R6 busy", br_ready, 0);
            if (ent_ready && got_n < 16) got[got_n++] = ent_data;
            prev_stall = !ent_ready;
            prev_d = ent_data;
            @(negedge clk);
        end
        ent_ready = 1;
        check(br_ready && !ent_valid, "R6 ready again", br_ready, 1);
    endtask

    task automatic compare(input string req);
        check(got_n == exp_n, req, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got[i] == expv[i], req, got[i], expv[i]);
    endtask

    task automatic t_reset_r1;
        check(!ent_valid, "R1 valid", ent_valid, 0);
        check(br_ready, "R1 ready", br_ready, 1);
    endtask

    task automatic t_nonvariant_r3;
        run_branch(32'h1234_5678, 0, 1, 0, 0, 0);
        build_exp(32'h1234_5678, 0, 1, 0);
        compare("R3 non-variant");
        run_branch(32'h1234_5678, 1, 0, 1, 0, 0);
        build_exp(32'h1234_5678, 1, 0, 1);
        compare("R3 capture off");
    endtask

    task automatic t_short_r4_r5;
        run_branch(32'h0001_ABCE, 1, 1, 0, 0, 0);
        build_exp(32'h0001_ABCE, 1, 1, 0);
        compare("R4 R5 short");
        run_branch(32'hFFFF_FFFF, 1, 1, 0, 0, 0);
        build_exp(32'hFFFF_FFFF, 1, 1, 0);
        compare("R5 short ones");
    endtask

    task automatic t_long_r4_r5;
        run_branch(32'h01AB_CDEF, 1, 1, 1, 0, 0);
        build_exp(32'h01AB_CDEF, 1, 1, 1);
        compare("R4 R5 long");
    endtask

    task automatic t_stall_r7;
        run_branch(32'h0135_7924, 1, 1, 1, 3, 0);
        build_exp(32'h0135_7924, 1, 1, 1);
        compare("R7 stalled long");
        run_branch(32'h0000_8642, 1, 1, 0, 2, 0);
        build_exp(32'h0000_8642, 1, 1, 0);
        compare("R7 stalled short");
    endtask

    task automatic t_disturb_r8;
        run_branch(32'h00C0_FFEE, 1, 1, 0, 2, 1);
        build_exp(32'h00C0_FFEE, 1, 1, 0);
        compare("R8 short held");
        run_branch(32'h0055_AA33, 1, 1, 1, 0, 1);
        build_exp(32'h0055_AA33, 1, 1, 1);
        compare("R8 long held");
    endtask

    task automatic t_midreset_r9;
        @(negedge clk);
        br_valid = 1; br_target = 32'h00FE_DCBA; br_variant = 1;
        cfg_capture_en = 1; cfg_long_addr = 1;
        @(negedge clk);
        br_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(!ent_valid && br_ready, "R9 after reset", ent_valid, 0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(!ent_valid, "R9 nothing pending", ent_valid, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_r1();
        t_nonvariant_r3();
        t_short_r4_r5();
        t_long_r4_r5();
        t_stall_r7();
        t_disturb_r8();
        t_midreset_r9();
        run_branch(32'h0000_0002, 1, 1, 0, 0, 0);
        build_exp(32'h0000_0002, 1, 1, 0);
        compare("R5 after reset");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule